// File: doc/BRIEF.md
# SPI Register Access Port

This block is an SPI target that lets a host read and write a bank of up to 64 registers, each 24 bits wide, over a four-wire serial link. The chip select is active high. Every transaction is one fixed 32-bit word, and the clock idles low. The leading bit of the word gives the direction, the next six bits give the register address, and the low 24 bits carry the data. On a read, the block fetches the addressed register while the frame is still running and returns its value in the low 24 bits of the word it shifts out in that same frame.

The serial pins are sampled by the local system clock through synchronizers. The serial clock must therefore run well below the system clock. Towards the registers the block drives a plain single-cycle bus: an address, write data, a write strobe, a read strobe, and read data that comes back one cycle after the read strobe. Each chip-select assertion carries exactly one transaction. A frame that ends early writes nothing.

Top module: `regspi_port`

## Requirements
- R1: While `spiCs` is low, `spiMiso` is 0 and serial clock edges cause neither `regRdStb` nor `regWrStb`.
- R2: Bits are taken from `spiMosi` MSB first on rising `spiSclk` edges. `spiMiso` changes only after falling edges, so each outgoing bit is valid at the next rising edge.
- R3: Frame bit 31 selects the direction (1 = write, 0 = read), and bits 30:25 give the register address 0..63 that appears on `regAddr`.
- R4: A write frame issues exactly one `regWrStb` pulse after all 32 bits have arrived. It carries `regWdata` equal to frame bits 23:0. Frame bit 24 has no effect on the value written.
- R5: If `spiCs` falls before the 32nd rising edge, no `regWrStb` is issued and the addressed register keeps its value.
- R6: A read frame issues exactly one `regRdStb` pulse before data bit 23 is shifted out. The word returned on `spiMiso` has bits 31:24 equal to 0 and bits 23:0 equal to the `regRdData` presented the cycle after the strobe.
- R7: A write frame issues no `regRdStb` and shifts out an all-zero word. A read frame issues no `regWrStb`. The two strobes are never high together.
- R8: Serial clocks beyond the 32nd in one chip-select assertion produce no further strobes and return 0 on `spiMiso`.
- R9: After reset `spiMiso`, `regRdStb` and `regWrStb` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | Serial clock from the host, idles low |
| spiCs | input | 1 | Chip select, active high |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host |
| regAddr | output | 6 | Register address of the current frame |
| regWdata | output | 24 | Write data towards the registers |
| regWrStb | output | 1 | One-cycle write strobe |
| regRdStb | output | 1 | One-cycle read strobe |
| regRdData | input | 24 | Read data, valid the cycle after `regRdStb` |

## Verification
A bit counter that is off by one shows up within the same frame in one of two ways: the write lands at an address or value shifted by a bit, or the returned word is misaligned by one position. Either is visible at the next readback of that register. If the direction flag were latched wrongly, a read would cause a write strobe, or a write would cause a read strobe, in the frame where it happens. A stale transmit register would return the previous frame's data on a write frame or after an aborted frame. Frames cut short and frames with extra clocks check that the counter neither wraps nor fires a second strobe.

// File: rtl/regspi_pkg.sv
package regspi_pkg;

  // Strobes from the frame control to the shift datapath
  typedef struct packed {
    logic clear;      // chip select idle: park outputs
    logic shiftIn;    // take one bit from the serial input
    logic shiftOut;   // falling serial edge seen
    logic dataPhase;  // outgoing bit belongs to the 24-bit data field
    logic hdrLatch;   // direction and address are complete in the shifter
    logic loadRd;     // register read data is valid now
  } ctlStb_t;

endpackage

// File: rtl/regspi_sync.sv
module regspi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csIn,
  input  logic mosiIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic csLvl,
  output logic mosiLvl
);
  logic [STAGES:0]   sclkPipe;
  logic [STAGES-1:0] csPipe;
  logic [STAGES-1:0] mosiPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '0;
      mosiPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[STAGES-1:0], sclkIn};
      csPipe   <= {csPipe[STAGES-2:0], csIn};
      mosiPipe <= {mosiPipe[STAGES-2:0], mosiIn};
    end
  end

  assign sclkRise = sclkPipe[STAGES-1] & ~sclkPipe[STAGES];
  assign sclkFall = ~sclkPipe[STAGES-1] & sclkPipe[STAGES];
  assign csLvl    = csPipe[STAGES-1];
  assign mosiLvl  = mosiPipe[STAGES-1];
endmodule

// File: rtl/regspi_ctrl.sv
module regspi_ctrl
  import regspi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 24
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkRise,
  input  logic    sclkFall,
  input  logic    csLvl,
  input  logic    frameWrite,
  output ctlStb_t ctl,
  output logic    rdStb,
  output logic    wrStb
);
  localparam int HDR_BITS = 1 + ADDR_W;
  localparam int FRAME_W  = HDR_BITS + 1 + DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT   = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] HDR_CNT    = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_START = CNT_W'(FRAME_W - DATA_W);

  logic [CNT_W-1:0] bitCnt;
  logic hdrPulse, rdPulse, loadRdQ, wrStbQ;

  always_comb begin
    ctl.clear     = ~csLvl;
    ctl.shiftIn   = csLvl & sclkRise & (bitCnt < FULL_CNT);
    ctl.shiftOut  = csLvl & sclkFall;
    ctl.dataPhase = (bitCnt >= DATA_START) & (bitCnt < FULL_CNT);
    ctl.hdrLatch  = hdrPulse;
    ctl.loadRd    = loadRdQ;
  end

  assign rdStb = rdPulse & ~frameWrite & csLvl;
  assign wrStb = wrStbQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      hdrPulse <= 1'b0;
      rdPulse  <= 1'b0;
      loadRdQ  <= 1'b0;
      wrStbQ   <= 1'b0;
    end else begin
      hdrPulse <= ctl.shiftIn & (bitCnt == HDR_CNT);
      rdPulse  <= hdrPulse;
      loadRdQ  <= rdStb;
      wrStbQ   <= ctl.shiftIn & (bitCnt == LAST_CNT) & frameWrite;
      if (!csLvl)
        bitCnt <= '0;
      else if (ctl.shiftIn)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  // R7: read and write strobes are mutually exclusive
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdStb, wrStb}));

  // R5: a write strobe only follows a complete frame
  assert_wr_full_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> (bitCnt == FULL_CNT));

  // R8: the bit counter saturates at the frame length
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT);

  // R1: an idle chip select leaves the counter at zero on the next cycle
  assert_idle_cnt_R1: assert property (@(posedge clk) disable iff (!rstN)
    !csLvl |=> (bitCnt == '0) || csLvl);
endmodule

// File: rtl/regspi_dp.sv
module regspi_dp
  import regspi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           ctl,
  input  logic              mosiLvl,
  input  logic [DATA_W-1:0] rdData,
  output logic              frameWrite,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              miso
);
  localparam int HDR_BITS = 1 + ADDR_W;
  localparam int SHIFT_W  = (DATA_W > HDR_BITS) ? DATA_W : HDR_BITS;

  logic [SHIFT_W-1:0] rxShift;
  logic [DATA_W-1:0]  txShift;
  logic [ADDR_W-1:0]  addrReg;
  logic               dirReg;
  logic               misoReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      addrReg <= '0;
      dirReg  <= 1'b0;
    end else begin
      if (ctl.shiftIn)
        rxShift <= {rxShift[SHIFT_W-2:0], mosiLvl};
      if (ctl.hdrLatch) begin
        addrReg <= rxShift[ADDR_W-1:0];
        dirReg  <= rxShift[ADDR_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      misoReg <= 1'b0;
    end else if (ctl.clear) begin
      txShift <= '0;
      misoReg <= 1'b0;
    end else begin
      if (ctl.loadRd)
        txShift <= rdData;
      else if (ctl.shiftOut && ctl.dataPhase)
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (ctl.shiftOut)
        misoReg <= ctl.dataPhase ? txShift[DATA_W-1] : 1'b0;
    end
  end

  assign frameWrite = dirReg;
  assign addr       = addrReg;
  assign wdata      = rxShift[DATA_W-1:0];
  assign miso       = misoReg;

  // R6: header and trailing bit times always carry 0 on the output
  assert_hdr_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftOut && !ctl.dataPhase && !ctl.clear) |=> !miso);

  // R1: idle chip select forces the output low on the next cycle
  assert_idle_miso_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> !miso);
endmodule

// File: rtl/regspi_port.sv
module regspi_port
  import regspi_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCs,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWrStb,
  output logic              regRdStb,
  input  logic [DATA_W-1:0] regRdData
);
  logic    sclkRise, sclkFall, csLvl, mosiLvl, frameWrite;
  ctlStb_t ctl;

  regspi_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN),
    .sclkIn(spiSclk), .csIn(spiCs), .mosiIn(spiMosi),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csLvl(csLvl), .mosiLvl(mosiLvl)
  );

  regspi_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csLvl(csLvl),
    .frameWrite(frameWrite), .ctl(ctl),
    .rdStb(regRdStb), .wrStb(regWrStb)
  );

  regspi_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mosiLvl(mosiLvl),
    .rdData(regRdData), .frameWrite(frameWrite),
    .addr(regAddr), .wdata(regWdata), .miso(spiMiso)
  );
endmodule

// File: tb/tb_regspi_port.sv
module tb_regspi_port;
  localparam int HP = 6;  // serial half period in system clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiCs = 1'b0, spiMosi = 1'b0;
  logic spiMiso;
  logic [5:0]  regAddr;
  logic [23:0] regWdata;
  logic        regWrStb, regRdStb;
  logic [23:0] regRdData = '0;

  always #10 clk = ~clk;  // 50 MHz

  regspi_port dut (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCs(spiCs),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .regAddr(regAddr),
    .regWdata(regWdata), .regWrStb(regWrStb), .regRdStb(regRdStb),
    .regRdData(regRdData)
  );

  // register bank behind the bus, and the bench's own expectation of it
  logic [23:0] bank [64];
  logic [23:0] expv [64];
  int wrCnt = 0, rdCnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (regWrStb) begin bank[regAddr] <= regWdata; wrCnt <= wrCnt + 1; end
    if (regRdStb) begin regRdData <= bank[regAddr]; rdCnt <= rdCnt + 1; end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWrite(input logic [5:0] a, input logic [23:0] d, input logic b24);
    return {1'b1, a, b24, d};
  endfunction

  function automatic logic [31:0] mkRead(input logic [5:0] a, input logic [24:0] junk);
    return {1'b0, a, junk};
  endfunction

  task automatic runFrame(input logic [31:0] tx, input int nbits, output logic [63:0] rx);
    @(negedge clk);
    spiCs = 1'b1; spiMosi = tx[31];
    repeat (HP) @(negedge clk);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      spiSclk = 1'b1;
      rx = {rx[62:0], spiMiso};
      repeat (HP) @(negedge clk);
      spiSclk = 1'b0;
      spiMosi = (i < 31) ? tx[30-i] : 1'b0;
      repeat (HP) @(negedge clk);
    end
    spiCs = 1'b0;
    repeat (4*HP) @(negedge clk);
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [23:0] d, input logic b24, input string req);
    logic [63:0] rx;
    int w0, r0;
    w0 = wrCnt; r0 = rdCnt;
    runFrame(mkWrite(a, d, b24), 32, rx);
    expv[a] = d;
    check(wrCnt - w0 == 1, {req, " one write strobe"}, wrCnt - w0, 1);
    check(rdCnt == r0, "R7 no read strobe on write", rdCnt - r0, 0);
    check(rx[31:0] == 32'h0, "R7 write frame returns zeros", rx[31:0], 0);
    check(bank[a] == d, {req, " written value"}, {8'h0, bank[a]}, {8'h0, d});
  endtask

  task automatic doRead(input logic [5:0] a, input string req);
    logic [63:0] rx;
    int w0, r0;
    w0 = wrCnt; r0 = rdCnt;
    runFrame(mkRead(a, 25'($urandom)), 32, rx);
    check(rdCnt - r0 == 1, "R6 one read strobe", rdCnt - r0, 1);
    check(wrCnt == w0, "R7 no write strobe on read", wrCnt - w0, 0);
    check(rx[31:0] == {8'h0, expv[a]}, req, rx[31:0], {8'h0, expv[a]});
  endtask

  initial begin
    logic [63:0] rx;
    int w0, r0;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) begin bank[i] = '0; expv[i] = '0; end
    repeat (5) @(negedge clk);
    // R9: reset state
    check(spiMiso == 1'b0 && regWrStb == 1'b0 && regRdStb == 1'b0, "R9 reset outputs idle",
          {29'h0, spiMiso, regWrStb, regRdStb}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R4 / R3: basic write and readback at both address ends
    doWrite(6'd0, 24'hABCDEF, 1'b0, "R4 addr0");
    doWrite(6'd63, 24'h123456, 1'b1, "R4 bit24 ignored R3 addr63");
    doRead(6'd63, "R6 read addr63");
    doRead(6'd0, "R3 read addr0");
    doWrite(6'd31, 24'hFFFFFF, 1'b0, "R4 all ones");
    doRead(6'd31, "R2 all-ones readback");

    // R5: frames cut short write nothing
    foreach (bank[i]) begin end
    w0 = wrCnt;
    runFrame(mkWrite(6'd0, 24'h00DEAD, 1'b0), 20, rx);
    check(wrCnt == w0, "R5 abort at 20 bits", wrCnt - w0, 0);
    runFrame(mkWrite(6'd0, 24'h00BEEF, 1'b0), 31, rx);
    check(wrCnt == w0, "R5 abort at 31 bits", wrCnt - w0, 0);
    doRead(6'd0, "R5 value kept after abort");
    check(spiMiso == 1'b0, "R1 miso low while deselected", spiMiso, 0);

    // R1: serial clocks with chip select low do nothing
    w0 = wrCnt; r0 = rdCnt;
    spiMosi = 1'b1;
    for (int i = 0; i < 40; i++) begin
      spiSclk = 1'b1; repeat (HP) @(negedge clk);
      spiSclk = 1'b0; repeat (HP) @(negedge clk);
      if (spiMiso !== 1'b0) check(0, "R1 miso during idle clocks", spiMiso, 0);
    end
    spiMosi = 1'b0;
    repeat (4*HP) @(negedge clk);
    check(wrCnt == w0 && rdCnt == r0, "R1 no strobes while deselected", wrCnt - w0 + rdCnt - r0, 0);
    doRead(6'd63, "R1 state untouched by idle clocks");

    // R8: extra clocks in one assertion
    w0 = wrCnt;
    runFrame(mkWrite(6'd9, 24'h5A5A5A, 1'b0), 40, rx);
    expv[9] = 24'h5A5A5A;
    check(wrCnt - w0 == 1, "R8 single write with extra clocks", wrCnt - w0, 1);
    check(bank[9] == 24'h5A5A5A, "R8 write value with extra clocks", {8'h0, bank[9]}, 32'h5A5A5A);
    r0 = rdCnt;
    runFrame(mkRead(6'd9, 25'h0), 40, rx);
    check(rdCnt - r0 == 1, "R8 single read with extra clocks", rdCnt - r0, 1);
    check(rx[39:8] == {8'h0, 24'h5A5A5A}, "R8 read word with extra clocks", rx[39:8], 32'h5A5A5A);
    check(rx[7:0] == 8'h0, "R8 extra bits are zero", {24'h0, rx[7:0]}, 0);

    // R2 / R3: random mix of writes and reads
    for (int n = 0; n < 40; n++) begin
      logic [5:0] a;
      a = 6'($urandom);
      if ($urandom % 2) doWrite(a, 24'($urandom), 1'($urandom), "R2 random write");
      else doRead(a, "R2 random read");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule